// File: doc/BRIEF.md
# Auto-Incrementing RAM Expansion Port

This block sits on a host's synchronous register bus and gives it access to a large byte-wide RAM through a few I/O offsets. The host loads a 24-bit pointer one byte at a time: low, middle and high. It then streams bytes through a single data offset. Each data access advances the pointer by one. The host can therefore fill or dump a long region with repeated accesses to the same offset, without reloading the address.

Carry between the pointer bytes follows an edge rule, not plain binary addition. A byte passes a carry into the next byte only when its bit 7 goes from 1 to 0 during an update. The rule applies the same way to the internal increment and to host writes of the low and middle bytes.

A one-bit bank register selects which of two firmware ROM pages appears in the host's firmware window. The block forms the ROM address from that bit and the host's page and offset.

Top module: `xramPort`

## Requirements
- R1: The bus offset is decoded after an AND with 0x8F. Offsets 0x80 and 0x84 select the low pointer byte, 0x81 and 0x85 the middle byte, 0x82 and 0x86 the high byte, 0x83 and 0x87 the data port, and 0x8F the bank register. Any other masked offset ignores writes and reads as 0x00.
- R2: A read strobe returns the selected register on `rdData` in the cycle after the strobe. Low and middle reads return the stored byte unchanged.
- R3: A read of the high pointer byte returns the stored value ORed with 0xF0.
- R4: A data-port access increments the low byte. If that update takes bit 7 of the low byte from 1 to 0, the middle byte increments. The same rule then carries from the middle byte into the high byte.
- R5: A host write to the low or middle byte that takes its bit 7 from 1 to 0 increments the next byte up. A write to the high byte never carries. The high byte wraps from 0xFF to 0x00 when it increments.
- R6: A data-port write stores `wrData` at the pointer modulo 2^RAM_ADDR_W. The pointer then advances as in R4.
- R7: A data-port read returns the RAM byte at the pointer in the cycle after the strobe. The pointer then advances, so back-to-back reads return consecutive bytes.
- R8: The bank register keeps only bit 0 of written data. It reads back as 0x00 or 0x01 and is 0 after reset.
- R9: `romAddr` equals {bank, (romPage - 0xC0) low ROM_PAGE_W bits, romOffset}. The ROM side has no write path.
- R10: Reset clears all three pointer bytes and the bank bit. RAM contents are left untouched.
- R11: A cycle with both strobes set acts as a write only. In the cycle after any cycle without a read, `rdData` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regOff | input | 8 | Register bus offset |
| wrStb | input | 1 | Write strobe |
| rdStb | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid the cycle after a read strobe |
| ramAddr | output | RAM_ADDR_W | RAM byte address (pointer modulo RAM size) |
| ramWe | output | 1 | RAM write enable |
| ramRe | output | 1 | RAM read enable |
| ramWdata | output | 8 | RAM write data |
| ramRdata | input | 8 | RAM read data, one cycle after ramRe |
| romPage | input | 8 | Firmware page the host addresses |
| romOffset | input | 8 | Byte within the firmware page |
| romAddr | output | 1+ROM_PAGE_W+8 | Firmware ROM address |

## Verification
The hardest state to reach is a data access that ripples a carry through all three bytes. The harder case is the one where the high byte then wraps from 0xFF to 0x00. The stimulus reaches it by writing the bytes in high, low, middle order, so that no write itself clears a set bit 7. A single data access then performs the full ripple.

The bench is built with a 1 KiB RAM, so the same pointers also exercise the modulo. A pointer of 0x060000 and a pointer of 0xFFFFFF fall on RAM bytes written earlier through other pointer values, and reading them back proves both the wrap and the carries.

// File: rtl/xramPkg.sv
package xramPkg;
  localparam int BYTE_W    = 8;
  localparam int PTR_BYTES = 3;
  localparam logic [7:0] OFF_MASK = 8'h8F;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LO,
    SEL_MID,
    SEL_HI,
    SEL_DATA,
    SEL_BANK
  } regSelE;

  typedef struct packed {
    logic   wrLo;
    logic   wrMid;
    logic   wrHi;
    logic   wrBank;
    logic   dataAcc;
    logic   dataWr;
    regSelE rdSel;
  } ctrlStrbT;

  function automatic regSelE decodeOff(input logic [7:0] off);
    regSelE sel;
    case (off & OFF_MASK)
      8'h80, 8'h84: sel = SEL_LO;
      8'h81, 8'h85: sel = SEL_MID;
      8'h82, 8'h86: sel = SEL_HI;
      8'h83, 8'h87: sel = SEL_DATA;
      8'h8F:        sel = SEL_BANK;
      default:      sel = SEL_NONE;
    endcase
    return sel;
  endfunction
endpackage

// File: rtl/xramCtrl.sv
module xramCtrl
  import xramPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic [7:0] regOff,
  input  logic     wrStb,
  input  logic     rdStb,
  output ctrlStrbT strb
);
  regSelE sel;
  logic   isWr;
  logic   isRd;

  always_comb begin
    sel  = decodeOff(regOff);
    isWr = wrStb;
    isRd = rdStb & ~wrStb;

    strb         = '0;
    strb.wrLo    = isWr && (sel == SEL_LO);
    strb.wrMid   = isWr && (sel == SEL_MID);
    strb.wrHi    = isWr && (sel == SEL_HI);
    strb.wrBank  = isWr && (sel == SEL_BANK);
    strb.dataAcc = (isWr || isRd) && (sel == SEL_DATA);
    strb.dataWr  = isWr && (sel == SEL_DATA);
    strb.rdSel   = isRd ? sel : SEL_NONE;
  end

  // R11: a write strobe suppresses any read select
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> (strb.rdSel == SEL_NONE));

  // R1: at most one register is written per cycle
  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrLo, strb.wrMid, strb.wrHi, strb.wrBank, strb.dataWr}));
endmodule

// File: rtl/xramPtrByte.sv
module xramPtrByte
  import xramPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [BYTE_W-1:0] loadVal,
  input  logic              bump,
  output logic [BYTE_W-1:0] q,
  output logic              carryOut
);
  logic [BYTE_W-1:0] base;
  logic [BYTE_W-1:0] nextVal;

  always_comb begin
    base     = load ? loadVal : q;
    nextVal  = base + {{(BYTE_W-1){1'b0}}, bump};
    carryOut = q[BYTE_W-1] & ~nextVal[BYTE_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= nextVal;
  end

  // R4 / R5: a carry is only produced by a falling bit 7
  assert_carry_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    carryOut |=> ($past(q[BYTE_W-1]) && !q[BYTE_W-1]));

  // R2: the byte holds when neither loaded nor bumped
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !bump) |=> $stable(q));
endmodule

// File: rtl/xramDatapath.sv
module xramDatapath
  import xramPkg::*;
#(
  parameter int RAM_ADDR_W = 20,
  parameter int ROM_PAGE_W = 4,
  parameter logic [7:0] ROM_BASE_PAGE = 8'hC0,
  localparam int ROM_ADDR_W = 1 + ROM_PAGE_W + BYTE_W,
  localparam int PTR_W = PTR_BYTES * BYTE_W
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrbT              strb,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [BYTE_W-1:0]     ramRdata,
  input  logic [7:0]            romPage,
  input  logic [7:0]            romOffset,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  ramWe,
  output logic                  ramRe,
  output logic [BYTE_W-1:0]     ramWdata,
  output logic [BYTE_W-1:0]     rdData,
  output logic [ROM_ADDR_W-1:0] romAddr
);
  logic [PTR_BYTES-1:0] loadByte;
  logic [PTR_BYTES:0]   carry;
  logic [PTR_W-1:0]     ptrFlat;
  logic [BYTE_W-1:0]    ptrLo, ptrMid, ptrHi;
  logic                 bankQ;
  logic [BYTE_W-1:0]    rdRegQ;
  logic                 dataSelQ;
  logic [7:0]           pageDelta;

  assign loadByte = {strb.wrHi, strb.wrMid, strb.wrLo};
  assign carry[0] = strb.dataAcc;

  for (genvar i = 0; i < PTR_BYTES; i++) begin : gPtr
    logic [BYTE_W-1:0] byteQ;
    logic              byteCarry;
    xramPtrByte uByte (
      .clk      (clk),
      .rstN     (rstN),
      .load     (loadByte[i]),
      .loadVal  (wrData),
      .bump     (carry[i]),
      .q        (byteQ),
      .carryOut (byteCarry)
    );
    // the top byte's carry is dropped, so the high byte wraps
    assign carry[i+1] = (i == PTR_BYTES-1) ? 1'b0 : byteCarry;
    assign ptrFlat[i*BYTE_W +: BYTE_W] = byteQ;
  end

  assign ptrLo  = ptrFlat[0 +: BYTE_W];
  assign ptrMid = ptrFlat[BYTE_W +: BYTE_W];
  assign ptrHi  = ptrFlat[2*BYTE_W +: BYTE_W];

  // RAM side: pointer modulo the RAM size
  assign ramAddr  = ptrFlat[RAM_ADDR_W-1:0];
  assign ramWe    = strb.dataWr;
  assign ramRe    = strb.dataAcc & ~strb.dataWr;
  assign ramWdata = wrData;

  // bank bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            bankQ <= 1'b0;
    else if (strb.wrBank) bankQ <= wrData[0];
  end

  // registered read-back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdRegQ   <= '0;
      dataSelQ <= 1'b0;
    end else begin
      dataSelQ <= (strb.rdSel == SEL_DATA);
      case (strb.rdSel)
        SEL_LO:   rdRegQ <= ptrLo;
        SEL_MID:  rdRegQ <= ptrMid;
        SEL_HI:   rdRegQ <= ptrHi | 8'hF0;
        SEL_BANK: rdRegQ <= {{(BYTE_W-1){1'b0}}, bankQ};
        default:  rdRegQ <= '0;
      endcase
    end
  end

  assign rdData = dataSelQ ? ramRdata : rdRegQ;

  // firmware ROM address
  assign pageDelta = romPage - ROM_BASE_PAGE;
  assign romAddr   = {bankQ, pageDelta[ROM_PAGE_W-1:0], romOffset};

  // R6: every data access advances the low byte by one
  assert_data_advance_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataAcc |=> (ptrLo == $past(ptrLo) + 8'd1));

  // R4: a data access from 0xFF in the low byte bumps the middle byte
  assert_lo_carry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataAcc && ptrLo == 8'hFF) |=> (ptrMid == $past(ptrMid) + 8'd1));

  // R3: high byte read-back always has the top nibble set
  assert_hi_nibble_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_HI) |=> (rdData[7:4] == 4'hF));

  // R8: bank only changes on a bank write
  assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrBank |=> $stable(bankQ));

  // R11: no read means zero read data next cycle
  assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_NONE) |=> (rdData == '0));

  // R6: RAM never sees a read and a write together
  assert_ram_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(ramWe && ramRe));
endmodule

// File: rtl/xramPort.sv
module xramPort
  import xramPkg::*;
#(
  parameter int RAM_ADDR_W = 20,
  parameter int ROM_PAGE_W = 4,
  localparam int ROM_ADDR_W = 1 + ROM_PAGE_W + 8
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [7:0]            regOff,
  input  logic                  wrStb,
  input  logic                  rdStb,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  ramWe,
  output logic                  ramRe,
  output logic [7:0]            ramWdata,
  input  logic [7:0]            ramRdata,
  input  logic [7:0]            romPage,
  input  logic [7:0]            romOffset,
  output logic [ROM_ADDR_W-1:0] romAddr
);
  ctrlStrbT strb;

  xramCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .regOff (regOff),
    .wrStb  (wrStb),
    .rdStb  (rdStb),
    .strb   (strb)
  );

  xramDatapath #(
    .RAM_ADDR_W (RAM_ADDR_W),
    .ROM_PAGE_W (ROM_PAGE_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .ramRdata  (ramRdata),
    .romPage   (romPage),
    .romOffset (romOffset),
    .ramAddr   (ramAddr),
    .ramWe     (ramWe),
    .ramRe     (ramRe),
    .ramWdata  (ramWdata),
    .rdData    (rdData),
    .romAddr   (romAddr)
  );
endmodule

// File: tb/xramPort_bench.sv
module xramPort_bench;
  localparam int RAM_ADDR_W = 10;
  localparam int ROM_PAGE_W = 4;
  localparam int NVEC = 56;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regOff = '0;
  logic wrStb = 1'b0, rdStb = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [RAM_ADDR_W-1:0] ramAddr;
  logic ramWe, ramRe;
  logic [7:0] ramWdata;
  logic [7:0] ramRdata;
  logic [7:0] romPage = 8'hC0, romOffset = '0;
  logic [ROM_PAGE_W+8:0] romAddr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  xramPort #(.RAM_ADDR_W(RAM_ADDR_W), .ROM_PAGE_W(ROM_PAGE_W)) u_xramPort (
    .clk(clk), .rstN(rstN), .regOff(regOff), .wrStb(wrStb), .rdStb(rdStb),
    .wrData(wrData), .rdData(rdData), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramRe(ramRe), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .romPage(romPage), .romOffset(romOffset), .romAddr(romAddr)
  );

  // behavioural synchronous RAM
  logic [7:0] ramMem [1 << RAM_ADDR_W];
  always @(posedge clk) begin
    if (ramWe) ramMem[ramAddr] <= ramWdata;
    if (ramRe) ramRdata <= ramMem[ramAddr];
  end

  // {op, offset, wdata, expected rdData next cycle, requirement}
  localparam logic [33:0] VEC [NVEC] = '{
    {OP_RD, 8'h80, 8'h00, 8'h00, 8'd10}, // R10 low cleared
    {OP_RD, 8'h82, 8'h00, 8'hF0, 8'd3},  // R3 high reads F0
    {OP_RD, 8'h8F, 8'h00, 8'h00, 8'd8},  // R8 bank reset
    {OP_WR, 8'h80, 8'h7E, 8'h00, 8'd1},
    {OP_WR, 8'h81, 8'h12, 8'h00, 8'd1},
    {OP_WR, 8'h82, 8'h00, 8'h00, 8'd1},
    {OP_RD, 8'h84, 8'h00, 8'h7E, 8'd1},  // R1 alias
    {OP_RD, 8'h85, 8'h00, 8'h12, 8'd2},  // R2
    {OP_WR, 8'h83, 8'hA1, 8'h00, 8'd6},  // R6 at 0x27E
    {OP_WR, 8'h87, 8'hA2, 8'h00, 8'd6},
    {OP_WR, 8'h83, 8'hA3, 8'h00, 8'd6},
    {OP_RD, 8'h80, 8'h00, 8'h81, 8'd6},
    {OP_WR, 8'h80, 8'h7E, 8'h00, 8'd5},  // R5 81->7E bumps mid
    {OP_RD, 8'h81, 8'h00, 8'h13, 8'd5},
    {OP_WR, 8'h80, 8'h7E, 8'h00, 8'd5},
    {OP_RD, 8'h81, 8'h00, 8'h13, 8'd5},
    {OP_WR, 8'h81, 8'h12, 8'h00, 8'd5},
    {OP_RD, 8'h83, 8'h00, 8'hA1, 8'd7},  // R7 back-to-back
    {OP_RD, 8'h83, 8'h00, 8'hA2, 8'd7},
    {OP_RD, 8'h87, 8'h00, 8'hA3, 8'd7},
    {OP_RD, 8'h80, 8'h00, 8'h81, 8'd7},
    {OP_WR, 8'h80, 8'hFF, 8'h00, 8'd4},
    {OP_WR, 8'h81, 8'hFF, 8'h00, 8'd4},
    {OP_WR, 8'h82, 8'h05, 8'h00, 8'd4},
    {OP_WR, 8'h83, 8'h5C, 8'h00, 8'd4},  // R4 full ripple
    {OP_RD, 8'h80, 8'h00, 8'h00, 8'd4},
    {OP_RD, 8'h81, 8'h00, 8'h00, 8'd4},
    {OP_RD, 8'h86, 8'h00, 8'hF6, 8'd4},
    {OP_WR, 8'h83, 8'h3C, 8'h00, 8'd6},  // R6 wraps to 0
    {OP_WR, 8'h80, 8'hFF, 8'h00, 8'd6},
    {OP_WR, 8'h81, 8'hFF, 8'h00, 8'd6},
    {OP_WR, 8'h82, 8'h05, 8'h00, 8'd6},
    {OP_RD, 8'h83, 8'h00, 8'h5C, 8'd6},
    {OP_RD, 8'h83, 8'h00, 8'h3C, 8'd6},
    {OP_WR, 8'h82, 8'hFF, 8'h00, 8'd5},
    {OP_WR, 8'h80, 8'hFF, 8'h00, 8'd5},
    {OP_WR, 8'h81, 8'hFF, 8'h00, 8'd5},
    {OP_RD, 8'h83, 8'h00, 8'h5C, 8'd5},
    {OP_RD, 8'h82, 8'h00, 8'hF0, 8'd5},  // R5 high wrapped
    {OP_RD, 8'h81, 8'h00, 8'h00, 8'd5},
    {OP_WR, 8'h81, 8'h80, 8'h00, 8'd5},
    {OP_WR, 8'h81, 8'h01, 8'h00, 8'd5},
    {OP_RD, 8'h82, 8'h00, 8'hF1, 8'd5},
    {OP_WR, 8'h8F, 8'hFF, 8'h00, 8'd8},
    {OP_RD, 8'h8F, 8'h00, 8'h01, 8'd8},  // R8 bit0 only
    {OP_WR, 8'h8F, 8'hFE, 8'h00, 8'd8},
    {OP_RD, 8'h8F, 8'h00, 8'h00, 8'd8},
    {OP_WR, 8'h88, 8'h55, 8'h00, 8'd1},
    {OP_RD, 8'h88, 8'h00, 8'h00, 8'd1},
    {OP_RD, 8'h8E, 8'h00, 8'h00, 8'd1},
    {OP_RD, 8'h80, 8'h00, 8'h00, 8'd1},
    {OP_WR, 8'h90, 8'h33, 8'h00, 8'd1},  // R1 mask aliases 0x90
    {OP_RD, 8'h80, 8'h00, 8'h33, 8'd1},
    {OP_WR, 8'h00, 8'h44, 8'h00, 8'd1},
    {OP_RD, 8'h80, 8'h00, 8'h33, 8'd1},
    {OP_RD, 8'h00, 8'h00, 8'h00, 8'd1}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rd, input logic wr, input logic [7:0] off, input logic [7:0] wd);
    rdStb = rd; wrStb = wr; regOff = off; wrData = wd;
  endtask

  initial begin
    logic [7:0] pendExp;
    int pendReq;
    drive(1'b0, 1'b0, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: each vector occupies one cycle, its result is checked
    // at the next falling edge while the following vector is applied
    for (int i = 0; i < NVEC; i++) begin
      if (i > 0) check({24'd0, rdData}, {24'd0, pendExp}, $sformatf("R%0d vec%0d", pendReq, i - 1));
      drive(VEC[i][33:32] == OP_RD, VEC[i][33:32] == OP_WR, VEC[i][31:24], VEC[i][23:16]);
      pendExp = VEC[i][15:8];
      pendReq = int'(VEC[i][7:0]);
      @(negedge clk);
    end
    check({24'd0, rdData}, {24'd0, pendExp}, $sformatf("R%0d vec%0d", pendReq, NVEC - 1));
    drive(1'b0, 1'b0, 8'h00, 8'h00);
    @(negedge clk);

    // R11: both strobes at once behave as a write
    drive(1'b1, 1'b1, 8'h81, 8'h22);
    @(negedge clk);
    check({24'd0, rdData}, 32'h0, "R11 no read data on dual strobe");
    drive(1'b1, 1'b0, 8'h81, 8'h00);
    @(negedge clk);
    check({24'd0, rdData}, 32'h22, "R11 dual strobe wrote middle");
    drive(1'b0, 1'b0, 8'h00, 8'h00);

    // R9: firmware ROM address
    romPage = 8'hC3; romOffset = 8'h5A;
    @(negedge clk);
    check({19'd0, romAddr}, 32'h035A, "R9 bank0 page3");
    drive(1'b0, 1'b1, 8'h8F, 8'h01);
    @(negedge clk);
    drive(1'b0, 1'b0, 8'h00, 8'h00);
    romPage = 8'hCF; romOffset = 8'hFF;
    @(negedge clk);
    check({19'd0, romAddr}, 32'h1FFF, "R9 bank1 pageF");
    romPage = 8'hC0; romOffset = 8'h00;
    @(negedge clk);
    check({19'd0, romAddr}, 32'h1000, "R9 bank1 page0");

    // R10: reset clears pointer and bank, RAM keeps its bytes
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check({19'd0, romAddr}, 32'h0000, "R10 bank cleared at ROM");
    drive(1'b1, 1'b0, 8'h80, 8'h00); @(negedge clk);
    check({24'd0, rdData}, 32'h00, "R10 low cleared");
    drive(1'b1, 1'b0, 8'h81, 8'h00); @(negedge clk);
    check({24'd0, rdData}, 32'h00, "R10 middle cleared");
    drive(1'b1, 1'b0, 8'h82, 8'h00); @(negedge clk);
    check({24'd0, rdData}, 32'hF0, "R10 high cleared");
    drive(1'b1, 1'b0, 8'h8F, 8'h00); @(negedge clk);
    check({24'd0, rdData}, 32'h00, "R10 bank cleared");
    drive(1'b1, 1'b0, 8'h83, 8'h00); @(negedge clk);
    check({24'd0, rdData}, 32'h3C, "R10 RAM retained at 0");
    drive(1'b0, 1'b0, 8'h00, 8'h00); @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule